// File: doc/BRIEF.md
# Fractional Baud Tick and Character Format Generator

This block makes the 16x oversampling tick that a UART transmitter and receiver use, and it works from a fixed reference clock. An integer divisor and a 3-bit fractional value set the rate. Each bit time lasts 16 times (divisor + 1) reference cycles, plus 0 to 7 extra cycles. The extra cycles are not bunched at the end of the bit. Each one lengthens one of the first sub-ticks of the bit, so the 16 ticks stay nearly evenly spaced.

A line-control value is written on the same bus. The block decodes it into the character length, the stop-bit count and the parity mode, and the serial shifters use these directly. Writes arrive on a plain write-enable, address and data bus. While the divisor is zero the tick generator is idle. Writing any of the three configuration registers restarts the divider from the start of a bit.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset no tick is produced, the divisor and the fractional value are zero, and the format outputs show 5 data bits (char_len = 5), one stop bit (two_stop = 0) and no parity (parity_mode = 0).
- R2: While the integer divisor register (address 1, wr_data[15:0]) holds zero, tick stays low.
- R3: With divisor D and fractional value F (address 2, wr_data[2:0]), the sub-ticks of each bit are numbered 0 to 15. Sub-tick j lasts D+1 reference cycles, plus one more cycle when j < F.
- R4: Sixteen consecutive sub-ticks, one whole bit, span exactly 16*D + F + 16 reference cycles.
- R5: tick is a pulse one clock cycle wide and is never high in two consecutive cycles.
- R6: A write to address 0, 1 or 2 restarts the divider at sub-tick 0. If the write is sampled at clock edge k, tick is low until edge k+L-1 and high in the cycle after that edge, where L is the length of sub-tick 0 from R3.
- R7: The line-control register (address 0, wr_data[5:0]) bits [1:0] give the character length as field + 5, output on char_len (5 to 8).
- R8: Line-control bit 2 set gives two stop bits (two_stop = 1). Clear gives one stop bit.
- R9: parity_mode is 0 (none) when line-control bit 5 is clear. When bit 5 is set, it is 1 (odd) if bit 3 is clear and 2 (even) if bit 3 is set.
- R10: The format outputs change only in response to a write to address 0. Writes to addresses 1, 2 and 3 leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 line control, 1 divisor, 2 fraction, 3 unused |
| wr_data | input | DIV_W (16) | Write data |
| tick | output | 1 | 16x oversampling tick pulse |
| char_len | output | 4 | Data bits per character (5 to 8) |
| two_stop | output | 1 | Two stop bits when set |
| parity_mode | output | 2 | 0 none, 1 odd, 2 even |

## Verification
Format outputs come straight from the line-control register, so they are valid in the cycle after the write edge. The bench samples them at the next falling edge. Tick timing is measured in whole clock edges between falling-edge samples. Counting starts at the falling edge right after the restarting write, where sub-tick 0 has already begun. The first tick therefore appears after L-1 edges, and each later gap equals the full length of its sub-tick. Sixteen gaps are summed to check the length of a whole bit.

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int DIV_W = 16,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [DIV_W-1:0] wr_data,
  output logic             tick,
  output logic [3:0]       char_len,
  output logic             two_stop,
  output logic [1:0]       parity_mode
);
  localparam int SUB_W = $clog2(OVS);
  localparam int CNT_W = DIV_W + 1;

  logic [5:0]       lcr_q;
  logic [DIV_W-1:0] div_q;
  logic [2:0]       frac_q;
  logic [CNT_W-1:0] cnt;
  logic [SUB_W-1:0] sub;
  logic [CNT_W-1:0] len;
  logic             running, cfg_wr, stretch;

  assign cfg_wr  = wr_en && (wr_addr != 2'd3);
  assign running = (div_q != '0);
  assign stretch = (CNT_W'(sub) < CNT_W'(frac_q));
  assign len     = CNT_W'(div_q) + CNT_W'(1) + CNT_W'(stretch);
  assign tick    = running && (cnt == len - CNT_W'(1));

  assign char_len    = 4'd5 + {2'b00, lcr_q[1:0]};
  assign two_stop    = lcr_q[2];
  assign parity_mode = !lcr_q[5] ? 2'd0 : (lcr_q[3] ? 2'd2 : 2'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lcr_q  <= '0;
      div_q  <= '0;
      frac_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0:    lcr_q  <= wr_data[5:0];
        2'd1:    div_q  <= wr_data;
        2'd2:    frac_q <= wr_data[2:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || cfg_wr) begin
      cnt <= '0;
      sub <= '0;
    end else if (running) begin
      if (tick) begin
        cnt <= '0;
        sub <= (sub == SUB_W'(OVS - 1)) ? '0 : sub + SUB_W'(1);
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  // R5
  tick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R10
  fmt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en && wr_addr == 2'd0) |-> $stable({char_len, two_stop, parity_mode}));

  // R6
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_wr) |-> !tick && sub == '0);

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> cnt < len);

  // R2
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> cnt == '0 && !tick);

  // R4
  sub_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!tick && !cfg_wr) |-> sub == $past(sub));
endmodule

// File: tb/sim_frac_baud_gen.sv
`timescale 1ns/1ps
module sim_frac_baud_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        tick;
  logic [3:0]  char_len;
  logic        two_stop;
  logic [1:0]  parity_mode;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  frac_baud_gen u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tick(tick), .char_len(char_len), .two_stop(two_stop), .parity_mode(parity_mode)
  );

  typedef struct packed {
    logic [15:0] d;
    logic [2:0]  f;
    logic [5:0]  l;
    logic [3:0]  len;
    logic        stp;
    logic [1:0]  par;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{16'd1,  3'd0, 6'h00, 4'd5, 1'b0, 2'd0},
    '{16'd2,  3'd3, 6'h27, 4'd8, 1'b1, 2'd1},
    '{16'd3,  3'd7, 6'h2D, 4'd6, 1'b1, 2'd2},
    '{16'd1,  3'd5, 6'h02, 4'd7, 1'b0, 2'd0},
    '{16'd16, 3'd1, 6'h08, 4'd5, 1'b0, 2'd0},
    '{16'd5,  3'd2, 6'h3B, 4'd8, 1'b0, 2'd2}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic gap(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick && n < 2000);
  endtask

  task automatic fmt(input string tag, input int len, input int stp, input int par);
    chk({tag, " R7 char_len"}, int'(char_len), len);
    chk({tag, " R8 two_stop"}, int'(two_stop), stp);
    chk({tag, " R9 parity_mode"}, int'(parity_mode), par);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n, tot, d, f, seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state and idle generator
    fmt("reset R1", 5, 0, 0);
    seen = 0;
    repeat (100) begin @(negedge clk); seen += int'(tick); end
    chk("R1 ticks after reset", seen, 0);

    // table of vectors
    for (int v = 0; v < NV; v++) begin
      d = int'(VEC[v].d);
      f = int'(VEC[v].f);
      wr(2'd0, {10'd0, VEC[v].l});
      wr(2'd2, {13'd0, VEC[v].f});
      wr(2'd1, VEC[v].d);
      fmt($sformatf("vec%0d", v), int'(VEC[v].len), int'(VEC[v].stp), int'(VEC[v].par));
      // R6 first tick after restart
      gap(n);
      chk($sformatf("vec%0d R6 first tick", v), n, d + (f > 0 ? 1 : 0));
      tot = 0;
      for (int j = 1; j <= 16; j++) begin
        int idx;
        idx = j % 16;
        gap(n);
        tot += n;
        // R3 per sub-tick length
        chk($sformatf("vec%0d R3 subtick %0d", v, idx), n, d + 1 + (idx < f ? 1 : 0));
      end
      // R4 whole bit
      chk($sformatf("vec%0d R4 bit period", v), tot, 16 * d + f + 16);
      @(negedge clk);
      // R5 pulse width
      chk($sformatf("vec%0d R5 tick width", v), int'(tick), 0);
    end

    // R10 writes to other addresses leave format alone
    wr(2'd0, 16'h002F);
    fmt("pre R10", 8, 1, 2);
    wr(2'd3, 16'h0000);
    wr(2'd1, 16'h0003);
    wr(2'd2, 16'h0000);
    fmt("post R10", 8, 1, 2);

    // R6 restart in the middle of a sub-tick
    wr(2'd1, 16'd4);
    wr(2'd2, 16'd2);
    gap(n); gap(n);
    repeat (3) @(negedge clk);
    wr(2'd2, 16'd2);
    gap(n);
    chk("mid R6 restart first tick", n, 5);
    gap(n);
    chk("mid R3 second subtick", n, 6);
    gap(n);
    chk("mid R3 third subtick", n, 5);

    // R2 zero divisor stops the generator
    wr(2'd1, 16'd0);
    seen = 0;
    repeat (300) begin @(negedge clk); seen += int'(tick); end
    chk("R2 ticks with zero divisor", seen, 0);
    wr(2'd2, 16'd7);
    seen = 0;
    repeat (100) begin @(negedge clk); seen += int'(tick); end
    chk("R2 ticks after fraction write", seen, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule